// File: doc/BRIEF.md
# Backup Low-Frequency Timekeeping Counter

A counter for always-on timekeeping. It advances on pulses from a chosen low-frequency source, which is one of an ultra-low-frequency RC tick, a 32768 Hz RC tick or a 32768 Hz crystal tick. A selection of "none" stops it. A power-of-two prescaler sets the count rate. One compare register can raise a match flag. It can also act as the counter's top value, so the count wraps early. In low-power mode the match ignores a programmable number of low-order bits.

Configuration writes come from the bus side. They are first held in staging registers and take effect on the next tick of the selected source. Until that tick, a per-register busy flag stays high. A write that hits a busy register is refused and an error pulse reports it. While the freeze input is high, writes only accumulate in staging and no busy flag rises. When freeze drops, every staged register takes effect on the same source tick. The count is read through a Gray-coded, two-flop synchronised copy.

Top module: `rtc_backup_counter`

## Requirements
- R1: After reset the read count is 0, both interrupt flags and all busy flags are 0, wrErr is 0, and the applied source is "none".
- R2: With source "none" (ctrl bits [1:0] = 0), ticks do not advance the counter. A write takes effect in the cycle after it, and no busy flag is raised.
- R3: With source 2 (RC) or 3 (crystal), the counter advances once every 2^d source ticks. Here d is ctrl bits [4:2], in the range 0 to 7.
- R4: With source 1 (ultra-low-frequency), d = 0 advances on every tick and any other d advances on every second tick.
- R5: While ctrl bit 9 (hold) is set, the counter and prescaler stay at zero. Clearing it restarts the count from zero.
- R6: With ctrl bit 8 (top) set, the counter wraps to 0 on the tick after it equals the compare value. Otherwise it runs to all-ones, then wraps to 0 and sets irq[0] (overflow).
- R7: irq[1] is set when a count step lands on a value equal to the compare value in every compared bit.
- R8: Masking applies only when the low-power register bit 0 is 1 and the source is 2 or 3. Then the match ignores the k low bits, where k is ctrl bits [7:5] and a value of 7 acts as 6. With source 1 nothing is masked.
- R9: busy[0] (ctrl), busy[1] (compare) and busy[2] (low-power) are each high from an accepted write until the source tick that applies it.
- R10: A write to a register whose busy flag is high is dropped, and wrErr is high in the next cycle.
- R11: While freeze is high, writes are staged with no busy flag and no effect. After freeze drops, all staged registers apply on the same source tick.
- R12: Writing 1 to clrIrq[0] or clrIrq[1] clears the matching flag. A flag event in the same cycle as its clear leaves the flag set.
- R13: countRd equals the internal count three cycles later, passed through Gray code and two synchronising flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ulfTick | input | 1 | Ultra-low-frequency source pulse (2 kHz rate) |
| lfrcTick | input | 1 | 32768 Hz RC source pulse |
| lfxoTick | input | 1 | 32768 Hz crystal source pulse |
| freeze | input | 1 | Hold staged writes until released |
| wrCtrl | input | 1 | Write strobe, control register |
| wrComp | input | 1 | Write strobe, compare register |
| wrLp | input | 1 | Write strobe, low-power mode register |
| wrData | input | CNT_W | Write data |
| clrIrq | input | 2 | Write-one-to-clear for irq flags |
| busy | output | 3 | Per-register write-in-flight flags |
| wrErr | output | 1 | Rejected-write pulse |
| irq | output | 2 | Flags: [0] overflow, [1] compare match |
| countRd | output | CNT_W | Synchronised count snapshot |

## Verification
A compare event and a flag clear can land in the same clock edge. The bench places the clear pulse in the same cycle as the source tick that moves the counter onto the compare value, and expects the flag to stay set. A separate clear with no event must then drop it. A second collision happens at freeze release: the ctrl and compare registers are staged together, and both busy flags must rise together and fall on the same tick. The hold bit carried in that commit, seen as a zero count, shows the pair was applied at once.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ULF  = 2'd1,
    SRC_LFRC = 2'd2,
    SRC_LFXO = 2'd3
  } srcSel_e;

  // bit 9 hold, bit 8 top, [7:5] lp ignore bits, [4:2] log2 divisor, [1:0] source
  typedef struct packed {
    logic       rstEn;
    logic       compTop;
    logic [2:0] lpBits;
    logic [2:0] divLog;
    srcSel_e    src;
  } ctrlCfg_t;

  typedef struct packed {
    logic loadLp;
    logic loadComp;
    logic loadCtrl;
  } commitStb_t;

  localparam int CFG_W = $bits(ctrlCfg_t);
  localparam int NREG  = $bits(commitStb_t);
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCtrl,
  input  logic              wrComp,
  input  logic              wrLp,
  input  logic [DATA_W-1:0] wrData,
  input  logic              freeze,
  input  logic              srcTick,
  input  logic              srcNone,
  output commitStb_t        stb,
  output ctrlCfg_t          stageCfg,
  output logic [DATA_W-1:0] stageComp,
  output logic              stageLp,
  output logic [NREG-1:0]   busy,
  output logic              wrErr
);
  logic [NREG-1:0] pending;
  logic [NREG-1:0] wrReq;
  logic [NREG-1:0] accept;
  logic            commit;

  assign wrReq  = {wrLp, wrComp, wrCtrl};
  assign busy   = pending & {NREG{!freeze && !srcNone}};
  assign accept = wrReq & ~busy;
  assign commit = !freeze && (srcTick || srcNone);
  assign stb    = commitStb_t'(pending & {NREG{commit}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= '0;
      stageCfg  <= ctrlCfg_t'('0);
      stageComp <= '0;
      stageLp   <= 1'b0;
      wrErr     <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (accept[i])   pending[i] <= 1'b1;
        else if (commit) pending[i] <= 1'b0;
      end
      if (accept[0]) stageCfg  <= ctrlCfg_t'(wrData[CFG_W-1:0]);
      if (accept[1]) stageComp <= wrData;
      if (accept[2]) stageLp   <= wrData[0];
      wrErr <= |(wrReq & busy);
    end
  end

  // R10
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> $past((wrReq & busy) != '0));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy[0] && !srcTick) |=> (busy[0] || freeze));
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ulfTick,
  input  logic             lfrcTick,
  input  logic             lfxoTick,
  input  commitStb_t       stb,
  input  ctrlCfg_t         stageCfg,
  input  logic [CNT_W-1:0] stageComp,
  input  logic             stageLp,
  input  logic [1:0]       clrIrq,
  output logic             srcTick,
  output logic             srcNone,
  output logic [CNT_W-1:0] cnt,
  output logic [1:0]       irq
);
  localparam int PRE_W  = $bits(stageCfg.divLog);
  localparam int DIV_W  = (1 << PRE_W) - 1;
  localparam int LP_MAX = 6;

  ctrlCfg_t         cfg;
  logic [CNT_W-1:0] comp0;
  logic             lpMode;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;
  logic [2:0]       lpShift;
  logic [CNT_W-1:0] cmpMask;
  logic [CNT_W-1:0] cntNext;
  logic             cntTick;
  logic             cmpEvt;
  logic             ovfEvt;

  always_comb begin
    unique case (cfg.src)
      SRC_ULF:  srcTick = ulfTick;
      SRC_LFRC: srcTick = lfrcTick;
      SRC_LFXO: srcTick = lfxoTick;
      default:  srcTick = 1'b0;
    endcase
  end
  assign srcNone = (cfg.src == SRC_NONE);

  always_comb begin
    if (cfg.src == SRC_ULF)
      divMask = (cfg.divLog == '0) ? '0 : DIV_W'(1);
    else
      divMask = DIV_W'((DIV_W+1)'(1) << cfg.divLog) - DIV_W'(1);
  end

  always_comb begin
    lpShift = 3'd0;
    if (lpMode && (cfg.src == SRC_LFRC || cfg.src == SRC_LFXO))
      lpShift = (cfg.lpBits > 3'(LP_MAX)) ? 3'(LP_MAX) : cfg.lpBits;
  end
  assign cmpMask = ~((CNT_W'(1) << lpShift) - CNT_W'(1));

  assign cntTick = srcTick && !cfg.rstEn && ((divCnt & divMask) == divMask);
  assign cntNext = (cfg.compTop && cnt == comp0) ? '0 : cnt + CNT_W'(1);
  assign cmpEvt  = cntTick && (((cntNext ^ comp0) & cmpMask) == '0);
  assign ovfEvt  = cntTick && (&cnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= ctrlCfg_t'('0);
      comp0  <= '0;
      lpMode <= 1'b0;
      divCnt <= '0;
      cnt    <= '0;
      irq    <= '0;
    end else begin
      if (stb.loadCtrl) cfg    <= stageCfg;
      if (stb.loadComp) comp0  <= stageComp;
      if (stb.loadLp)   lpMode <= stageLp;
      if (cfg.rstEn)    divCnt <= '0;
      else if (srcTick) divCnt <= divCnt + DIV_W'(1);
      if (cfg.rstEn)    cnt    <= '0;
      else if (cntTick) cnt    <= cntNext;
      irq[0] <= ovfEvt | (irq[0] & ~clrIrq[0]);
      irq[1] <= cmpEvt | (irq[1] & ~clrIrq[1]);
    end
  end

  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfg.rstEn |=> (cnt == '0));

  // R3
  still_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntTick && !cfg.rstEn) |=> $stable(cnt));

  // R6
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntTick && cfg.compTop && cnt == comp0) |=> (cnt == '0));

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpEvt && clrIrq[1]) |=> irq[1]);
endmodule

// File: rtl/rtc_graysnap.sv
module rtc_graysnap #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] binIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] grayQ;
  logic [W-1:0] syncA;
  logic [W-1:0] syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grayQ <= '0;
      syncA <= '0;
      syncB <= '0;
    end else begin
      grayQ <= binIn ^ (binIn >> 1);
      syncA <= grayQ;
      syncB <= syncA;
    end
  end

  always_comb begin
    binOut[W-1] = syncB[W-1];
    for (int i = W - 2; i >= 0; i--) binOut[i] = binOut[i+1] ^ syncB[i];
  end
endmodule

// File: rtl/rtc_backup_counter.sv
module rtc_backup_counter
  import rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ulfTick,
  input  logic             lfrcTick,
  input  logic             lfxoTick,
  input  logic             freeze,
  input  logic             wrCtrl,
  input  logic             wrComp,
  input  logic             wrLp,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       clrIrq,
  output logic [2:0]       busy,
  output logic             wrErr,
  output logic [1:0]       irq,
  output logic [CNT_W-1:0] countRd
);
  commitStb_t       stb;
  ctrlCfg_t         stageCfg;
  logic [CNT_W-1:0] stageComp;
  logic             stageLp;
  logic             srcTick;
  logic             srcNone;
  logic [CNT_W-1:0] cnt;

  rtc_ctrl #(.DATA_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrCtrl(wrCtrl), .wrComp(wrComp), .wrLp(wrLp),
    .wrData(wrData), .freeze(freeze), .srcTick(srcTick), .srcNone(srcNone),
    .stb(stb), .stageCfg(stageCfg), .stageComp(stageComp), .stageLp(stageLp),
    .busy(busy), .wrErr(wrErr)
  );

  rtc_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rstN(rstN), .ulfTick(ulfTick), .lfrcTick(lfrcTick),
    .lfxoTick(lfxoTick), .stb(stb), .stageCfg(stageCfg), .stageComp(stageComp),
    .stageLp(stageLp), .clrIrq(clrIrq), .srcTick(srcTick), .srcNone(srcNone),
    .cnt(cnt), .irq(irq)
  );

  rtc_graysnap #(.W(CNT_W)) snap_i (
    .clk(clk), .rstN(rstN), .binIn(cnt), .binOut(countRd)
  );
endmodule

// File: tb/rtc_backup_counter_tb_top.sv
module rtc_backup_counter_tb_top;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ulfTick = 1'b0, lfrcTick = 1'b0, lfxoTick = 1'b0;
  logic          freeze = 1'b0;
  logic          wrCtrl = 1'b0, wrComp = 1'b0, wrLp = 1'b0;
  logic [CW-1:0] wrData = '0;
  logic [1:0]    clrIrq = '0;
  logic [2:0]    busy;
  logic          wrErr;
  logic [1:0]    irq;
  logic [CW-1:0] countRd;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  rtc_backup_counter #(.CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .ulfTick(ulfTick), .lfrcTick(lfrcTick),
    .lfxoTick(lfxoTick), .freeze(freeze), .wrCtrl(wrCtrl), .wrComp(wrComp),
    .wrLp(wrLp), .wrData(wrData), .clrIrq(clrIrq), .busy(busy), .wrErr(wrErr),
    .irq(irq), .countRd(countRd)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk(bit rst, bit top, int lp, int dv, int src);
    return CW'({rst, top, 3'(lp), 3'(dv), 2'(src)});
  endfunction

  function automatic int expCount(int src, int dv, int n);
    if (src == 1) return (dv == 0) ? n : (n >> 1);
    return n >> dv;
  endfunction

  task automatic tickN(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ulfTick = 1; lfrcTick = 1; lfxoTick = 1;
      @(negedge clk); ulfTick = 0; lfrcTick = 0; lfxoTick = 0;
    end
  endtask

  task automatic wrC(logic [CW-1:0] v);
    @(negedge clk); wrCtrl = 1; wrData = v;
    @(negedge clk); wrCtrl = 0;
  endtask

  task automatic wrCmp(logic [CW-1:0] v);
    @(negedge clk); wrComp = 1; wrData = v;
    @(negedge clk); wrComp = 0;
  endtask

  task automatic wrL(logic [CW-1:0] v);
    @(negedge clk); wrLp = 1; wrData = v;
    @(negedge clk); wrLp = 0;
  endtask

  task automatic clrFlags(logic [1:0] m);
    @(negedge clk); clrIrq = m;
    @(negedge clk); clrIrq = 0;
  endtask

  task automatic readCnt(output int v);
    repeat (5) @(negedge clk);
    v = int'(countRd);
  endtask

  task automatic setup(int src, int dv, int lp, bit top, int comp, int lpm);
    wrC(mk(1, top, lp, dv, src));
    tickN(2);
    wrCmp(CW'(comp));
    wrL(CW'(lpm));
    tickN(1);
    wrC(mk(0, top, lp, dv, src));
    tickN(1);
    clrFlags(2'b11);
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int v;
    int seedv;
    seedv = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", countRd, 0);
    chk("R1 irq", irq, 0);
    chk("R1 busy", busy, 0);
    chk("R1 wrErr", wrErr, 0);

    // R2 no source: ticks ignored, writes apply without busy
    tickN(3);
    readCnt(v); chk("R2 no advance", v, 0);
    wrC(mk(0, 0, 0, 0, 2));
    chk("R2 no busy", busy, 0);
    tickN(3);
    readCnt(v); chk("R2 applied next cycle", v, 3);

    // R3 / R4 directed
    setup(2, 2, 0, 0, 4095, 0); tickN(11);
    readCnt(v); chk("R3 rc div4", v, 2);
    setup(3, 7, 0, 0, 4095, 0); tickN(300);
    readCnt(v); chk("R3 xo div128", v, 2);
    setup(1, 0, 0, 0, 4095, 0); tickN(9);
    readCnt(v); chk("R4 ulf 2k", v, 9);
    setup(1, 5, 0, 0, 4095, 0); tickN(9);
    readCnt(v); chk("R4 ulf 1k", v, 4);

    // R5 hold then restart
    setup(2, 0, 0, 0, 4095, 0); tickN(7);
    wrC(mk(1, 0, 0, 0, 2)); tickN(3);
    readCnt(v); chk("R5 held zero", v, 0);
    wrC(mk(0, 0, 0, 0, 2)); tickN(1); tickN(4);
    readCnt(v); chk("R5 restart from zero", v, 4);

    // R6 / R7 top mode with compare 5
    setup(2, 0, 0, 1, 5, 0);
    tickN(4);
    chk("R7 no match yet", irq[1], 0);
    tickN(1);
    chk("R7 match at compare", irq[1], 1);
    tickN(8);
    readCnt(v); chk("R6 top wrap", v, 13 % 6);
    clrFlags(2'b10);
    chk("R12 clear", irq[1], 0);
    // count now 1: three ticks to 4, then tick+clear collide onto 5
    tickN(3);
    @(negedge clk); lfrcTick = 1; clrIrq = 2'b10;
    @(negedge clk); lfrcTick = 0; clrIrq = 0;
    chk("R12 set wins over clear", irq[1], 1);
    chk("R6 no overflow in top mode", irq[0], 0);

    // R6 free-run overflow
    setup(2, 0, 0, 0, 4095, 0);
    tickN(4095);
    readCnt(v); chk("R6 at all-ones", v, 4095);
    chk("R6 overflow not yet", irq[0], 0);
    tickN(1);
    readCnt(v); chk("R6 wrapped", v, 0);
    chk("R6 overflow flag", irq[0], 1);

    // R8 low-power masking
    setup(2, 0, 2, 0, 9, 1); tickN(8);
    chk("R8 masked match at 8", irq[1], 1);
    setup(2, 0, 2, 0, 9, 0); tickN(8);
    chk("R8 no mask without lp mode", irq[1], 0);
    tickN(1);
    chk("R8 exact match at 9", irq[1], 1);
    setup(1, 0, 2, 0, 9, 1); tickN(8);
    chk("R8 ulf never masks", irq[1], 0);
    setup(3, 0, 7, 0, 70, 1); tickN(63);
    chk("R8 sat before 64", irq[1], 0);
    tickN(1);
    chk("R8 field 7 acts as 6", irq[1], 1);

    // R9 / R10 busy and rejection
    setup(2, 0, 0, 0, 4095, 0); tickN(2);
    wrC(mk(0, 0, 0, 0, 2));
    chk("R9 busy ctrl", busy, 3'b001);
    wrC(mk(1, 0, 0, 0, 2));
    chk("R10 wrErr", wrErr, 1);
    @(negedge clk);
    chk("R10 wrErr one cycle", wrErr, 0);
    tickN(1);
    chk("R9 busy cleared by tick", busy, 0);
    tickN(2);
    readCnt(v); chk("R10 rejected write not applied", v, 5);

    // R11 freeze staging
    setup(2, 0, 0, 0, 4095, 0); tickN(3);
    @(negedge clk); freeze = 1;
    wrC(mk(1, 0, 0, 0, 2));
    wrCmp(CW'(100));
    chk("R11 no busy while frozen", busy, 0);
    tickN(2);
    readCnt(v); chk("R11 staged no effect", v, 5);
    @(negedge clk); freeze = 0;
    @(negedge clk);
    chk("R11 busy after release", busy, 3'b011);
    tickN(1);
    chk("R11 both applied together", busy, 0);
    tickN(2);
    readCnt(v); chk("R11 hold applied", v, 0);

    // R3 / R4 / R13 random
    for (int it = 0; it < 20; it++) begin
      int src = 1 + int'($urandom % 3);
      int dv = int'($urandom % 8);
      int n = int'($urandom % 200);
      setup(src, dv, 0, 0, 4095, 0);
      tickN(n);
      readCnt(v);
      chk((src == 1) ? "R4 random R13" : "R3 random R13", v, expCount(src, dv, n));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule